// File: doc/BRIEF.md
# I2C Bus Master Controller

A register-mapped controller that drives a two-wire open-drain bus as its only master on the local side. Software sees five 16-bit registers: an address holding register, a clock divider, a control word, a status word and a data port. Edges on control bits start the bus actions. When the host bit goes from 0 to 1, the controller issues a START. When it goes from 1 to 0, the controller issues a STOP. Writing the repeat bit while the controller owns the bus issues a repeated START.

With the direction bit set, writing the data port sends that byte MSB first and samples the acknowledge on the ninth clock. With the direction bit clear, reading the data port returns the last received byte and starts reception of the next byte. The controller acknowledges that byte on the ninth clock unless the no-acknowledge bit is set. After the ninth clock of every byte a flag is raised, and software clears it by writing 0 to it.

A bus monitor synchronises both lines and tracks START and STOP from any master, which gives a bus-busy indication. While the enable bit is 0, everything except the register contents is held in reset and both lines are released.

Top module: `i2c_host_ctrl`

## Requirements
- R1: After reset, all five registers read 0 and neither bus line is pulled low.
- R2: Byte offsets are 0x00 address, 0x04 divider, 0x08 control and 0x0C status, and 0x10 is the data port. The address and divider registers read back what was written. Control keeps bits 7 (enable), 5 (host), 4 (direction, 1 = transmit) and 3 (no-acknowledge), and reads 0 in every other bit.
- R3: A 0 to 1 write of control bit 5 while status bit 5 (busy) is 0 produces exactly one START on the bus, and busy then reads 1.
- R4: A 1 to 0 write of control bit 5 while the controller owns the bus produces one STOP, after which busy reads 0.
- R5: In transmit direction, a data write sends the byte MSB first. After the ninth clock, status bit 1 (flag) is 1 and status bit 0 holds the sampled acknowledge, where 1 means no acknowledge.
- R6: In receive direction, a data read returns the last received byte and clocks in the next byte. On the ninth clock the controller pulls SDA low unless control bit 3 is 1. It then sets the flag.
- R7: Writing control bit 2 with bit 5 still 1 gives one new START with no STOP before it. Busy stays 1, and bit 2 reads back 0.
- R8: Writing 0 to status bit 1 clears the flag, and writing 1 to it leaves the flag unchanged.
- R9: The SCL period is (divider + 2) × 4 × QUARTER_MUL input clocks (768 for divider 0x16 at default parameters), with high and low halves of equal length.
- R10: During data and acknowledge bits, SDA changes only while SCL is low, so a byte creates no START or STOP on the bus.
- R11: Busy follows START and STOP made by another master. A host-bit set while busy is 1 produces no START.
- R12: Clearing enable in the middle of a byte releases both lines within two clocks and clears the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Register byte offset |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe (has a side effect only on the data port) |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i |
| scl_i | input | 1 | Sampled SCL line |
| sda_i | input | 1 | Sampled SDA line |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low |

## Verification
The bench keeps the default parameters: a 6-bit divider and a quarter-period multiplier of 8. This lets it measure the full 768-clock SCL period at divider 0x16 and its 384-clock high half. It then sets the divider to 0, which gives a 64-clock bit time, so several transmit and receive bytes, a repeated START, a foreign master's START/STOP and an enable drop mid-byte all fit in a short run. A bus model acts as an acknowledging or sending slave, counts every START and STOP, and checks each transmitted byte against a queue that the driver fills.

// File: rtl/i2c_host_pkg.sv
`timescale 1ns/1ps
package i2c_host_pkg;
  localparam int REG_W = 16;

  localparam logic [4:0] OFS_ADR = 5'h00;
  localparam logic [4:0] OFS_DIV = 5'h04;
  localparam logic [4:0] OFS_CTL = 5'h08;
  localparam logic [4:0] OFS_STA = 5'h0C;
  localparam logic [4:0] OFS_DAT = 5'h10;

  localparam int CTL_EN   = 7;
  localparam int CTL_HOST = 5;
  localparam int CTL_TX   = 4;
  localparam int CTL_NACK = 3;
  localparam int CTL_RS   = 2;
  localparam logic [7:0] CTL_KEEP = 8'hB8;

  localparam int STA_BUSY = 5;
  localparam int STA_FLAG = 1;
  localparam int STA_NACK = 0;

  typedef enum logic [2:0] {EG_IDLE, EG_START, EG_BIT, EG_HOLD, EG_STOP} eng_st_e;
endpackage

// File: rtl/i2c_host_tick.sv
`timescale 1ns/1ps
module i2c_host_tick #(
  parameter int DIV_W       = 6,
  parameter int QUARTER_MUL = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             srst_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  localparam int CNT_W = DIV_W + $clog2(QUARTER_MUL) + 3;

  logic [CNT_W-1:0] cnt_q, lim;

  // quarter of an SCL period: (div + 2) * QUARTER_MUL clocks
  assign lim    = CNT_W'((32'(div_i) + 32'd2) * 32'(QUARTER_MUL) - 32'd1);
  assign tick_o = !srst_i && (cnt_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (srst_i || cnt_q >= lim) cnt_q <= '0;
    else                          cnt_q <= cnt_q + 1'b1;
  end

  assert_tick_gap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/i2c_host_busmon.sv
`timescale 1ns/1ps
module i2c_host_busmon (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic srst_i,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s_o,
  output logic busy_o
);
  logic [1:0] scl_sync, sda_sync;
  logic       scl_d, sda_d, busy_q;
  logic       start_det, stop_det;

  assign start_det = scl_d && scl_sync[1] && sda_d && !sda_sync[1];
  assign stop_det  = scl_d && scl_sync[1] && !sda_d && sda_sync[1];
  assign sda_s_o   = sda_sync[1];
  assign busy_o    = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sync <= 2'b11; sda_sync <= 2'b11;
      scl_d <= 1'b1; sda_d <= 1'b1; busy_q <= 1'b0;
    end else if (srst_i) begin
      scl_sync <= 2'b11; sda_sync <= 2'b11;
      scl_d <= 1'b1; sda_d <= 1'b1; busy_q <= 1'b0;
    end else begin
      scl_sync <= {scl_sync[0], scl_i};
      sda_sync <= {sda_sync[0], sda_i};
      scl_d    <= scl_sync[1];
      sda_d    <= sda_sync[1];
      if (start_det)     busy_q <= 1'b1;
      else if (stop_det) busy_q <= 1'b0;
    end
  end

  assert_busy_on_start_R11: assert property (@(posedge clk_i) disable iff (!rst_ni || srst_i)
    start_det |=> busy_o);
  assert_idle_on_stop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni || srst_i)
    stop_det |=> !busy_o);
endmodule

// File: rtl/i2c_host_engine.sv
`timescale 1ns/1ps
module i2c_host_engine
  import i2c_host_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       srst_i,
  input  logic       tick_i,
  input  logic       sda_s_i,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       tx_i,
  input  logic       rx_i,
  input  logic       nack_i,
  input  logic [7:0] tx_byte_i,
  output logic       scl_oe_o,
  output logic       sda_oe_o,
  output logic       ready_o,
  output logic       done_o,
  output logic       ack_o,
  output logic [7:0] rx_byte_o
);
  eng_st_e    st_q;
  logic [1:0] ph_q;
  logic [3:0] bit_cnt_q;
  logic [7:0] sh_q;
  logic       txm_q, nack_q, scl_oe_q, sda_oe_q, done_q, ack_q;
  logic       last;

  assign last      = (bit_cnt_q == 4'd8);
  assign scl_oe_o  = scl_oe_q;
  assign sda_oe_o  = sda_oe_q;
  assign ready_o   = (st_q == EG_HOLD);
  assign done_o    = done_q;
  assign ack_o     = ack_q;
  assign rx_byte_o = sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni || srst_i) begin
      st_q <= EG_IDLE; ph_q <= '0; bit_cnt_q <= '0; sh_q <= '0;
      txm_q <= 1'b0; nack_q <= 1'b0; scl_oe_q <= 1'b0; sda_oe_q <= 1'b0;
      done_q <= 1'b0; ack_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        EG_IDLE: if (start_i) begin st_q <= EG_START; ph_q <= '0; end
        EG_HOLD: begin
          ph_q <= '0;
          if (start_i)     st_q <= EG_START;
          else if (stop_i) st_q <= EG_STOP;
          else if (tx_i || rx_i) begin
            st_q      <= EG_BIT;
            sh_q      <= tx_i ? tx_byte_i : 8'h00;
            txm_q     <= tx_i;
            nack_q    <= nack_i;
            bit_cnt_q <= '0;
          end
        end
        EG_START: if (tick_i) begin
          ph_q <= ph_q + 2'd1;
          case (ph_q)
            2'd0: sda_oe_q <= 1'b0;
            2'd1: scl_oe_q <= 1'b0;
            2'd2: sda_oe_q <= 1'b1;  // SDA falls, SCL high
            2'd3: begin scl_oe_q <= 1'b1; st_q <= EG_HOLD; end
          endcase
        end
        EG_STOP: if (tick_i) begin
          ph_q <= ph_q + 2'd1;
          case (ph_q)
            2'd0: sda_oe_q <= 1'b1;
            2'd1: scl_oe_q <= 1'b0;
            2'd2: sda_oe_q <= 1'b0;  // SDA rises, SCL high
            2'd3: st_q <= EG_IDLE;
          endcase
        end
        EG_BIT: if (tick_i) begin
          ph_q <= ph_q + 2'd1;
          case (ph_q)
            2'd0: sda_oe_q <= last ? (!txm_q && !nack_q) : (txm_q && !sh_q[7]);
            2'd1: scl_oe_q <= 1'b0;
            2'd2: if (!last) sh_q <= {sh_q[6:0], sda_s_i};
                  else       ack_q <= sda_s_i;
            2'd3: begin
              scl_oe_q <= 1'b1;
              if (last) begin st_q <= EG_HOLD; done_q <= 1'b1; end
              else bit_cnt_q <= bit_cnt_q + 4'd1;
            end
          endcase
        end
        default: st_q <= EG_IDLE;
      endcase
    end
  end

  assert_sda_moves_scl_low_R10: assert property (@(posedge clk_i) disable iff (!rst_ni || srst_i)
    (st_q == EG_BIT && !$stable(sda_oe_q)) |-> scl_oe_q);
  assert_hold_keeps_scl_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni || srst_i)
    (st_q == EG_HOLD) |-> scl_oe_q);
  assert_release_on_disable_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_i |=> (!scl_oe_o && !sda_oe_o));
endmodule

// File: rtl/i2c_host_ctrl.sv
`timescale 1ns/1ps
module i2c_host_ctrl
  import i2c_host_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int DIV_W       = 6,
  parameter int QUARTER_MUL = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe_o,
  output logic              sda_oe_o
);
  logic [7:0]       adr_q, ctl_q;
  logic [DIV_W-1:0] div_q;
  logic             flag_q, rx_nack_q;
  logic             en, srst, tick, sda_s, busy;
  logic             wr_ctl, wr_sta, cmd_start, cmd_stop, cmd_tx, cmd_rx;
  logic             eng_ready, eng_done, eng_ack;
  logic [7:0]       rx_byte;
  logic             unused_bits;

  assign unused_bits = ^wdata_i[REG_W-1:8];
  assign en     = ctl_q[CTL_EN];
  assign srst   = !en;
  assign wr_ctl = wr_i && (addr_i == ADDR_W'(OFS_CTL));
  assign wr_sta = wr_i && (addr_i == ADDR_W'(OFS_STA));

  // control-bit edges become bus commands
  assign cmd_start = en && wr_ctl && wdata_i[CTL_HOST] &&
                     ((!ctl_q[CTL_HOST] && !busy) || (ctl_q[CTL_HOST] && wdata_i[CTL_RS] && eng_ready));
  assign cmd_stop  = en && wr_ctl && ctl_q[CTL_HOST] && !wdata_i[CTL_HOST];
  assign cmd_tx    = en && wr_i && (addr_i == ADDR_W'(OFS_DAT)) && ctl_q[CTL_HOST] && ctl_q[CTL_TX];
  assign cmd_rx    = en && rd_i && (addr_i == ADDR_W'(OFS_DAT)) && ctl_q[CTL_HOST] && !ctl_q[CTL_TX];

  i2c_host_tick #(.DIV_W(DIV_W), .QUARTER_MUL(QUARTER_MUL)) u_tick (
    .clk_i, .rst_ni, .srst_i(srst), .div_i(div_q), .tick_o(tick));

  i2c_host_busmon u_busmon (
    .clk_i, .rst_ni, .srst_i(srst), .scl_i, .sda_i, .sda_s_o(sda_s), .busy_o(busy));

  i2c_host_engine u_engine (
    .clk_i, .rst_ni, .srst_i(srst), .tick_i(tick), .sda_s_i(sda_s),
    .start_i(cmd_start), .stop_i(cmd_stop), .tx_i(cmd_tx), .rx_i(cmd_rx),
    .nack_i(ctl_q[CTL_NACK]), .tx_byte_i(wdata_i[7:0]),
    .scl_oe_o, .sda_oe_o, .ready_o(eng_ready), .done_o(eng_done),
    .ack_o(eng_ack), .rx_byte_o(rx_byte));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      adr_q <= '0; div_q <= '0; ctl_q <= '0;
    end else if (wr_i) begin
      if (addr_i == ADDR_W'(OFS_ADR)) adr_q <= wdata_i[7:0];
      if (addr_i == ADDR_W'(OFS_DIV)) div_q <= wdata_i[DIV_W-1:0];
      if (wr_ctl)                     ctl_q <= wdata_i[7:0] & CTL_KEEP;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni || srst) begin
      flag_q <= 1'b0; rx_nack_q <= 1'b0;
    end else if (eng_done) begin
      flag_q <= 1'b1; rx_nack_q <= eng_ack;
    end else if (wr_sta && !wdata_i[STA_FLAG]) begin
      flag_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_W'(OFS_ADR): rdata_o[7:0] = adr_q;
      ADDR_W'(OFS_DIV): rdata_o[DIV_W-1:0] = div_q;
      ADDR_W'(OFS_CTL): rdata_o[7:0] = ctl_q;
      ADDR_W'(OFS_STA): begin
        rdata_o[STA_BUSY] = busy;
        rdata_o[STA_FLAG] = flag_q;
        rdata_o[STA_NACK] = rx_nack_q;
      end
      ADDR_W'(OFS_DAT): rdata_o[7:0] = rx_byte;
      default: rdata_o = '0;
    endcase
  end

  assert_flag_w1_keeps_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && wr_sta && wdata_i[STA_FLAG]) |=> flag_q);
endmodule

// File: tb/i2c_host_ctrl_bench.sv
`timescale 1ns/1ps
module i2c_host_ctrl_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic [4:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [15:0] wdata = '0, rdata;
  logic        scl_oe, sda_oe;
  logic        tb_sda_low = 1'b0, slv_low = 1'b0;
  wire         scl_w = !scl_oe;
  wire         sda_w = !(sda_oe || tb_sda_low || slv_low);

  int checks = 0, errors = 0;
  int start_cnt = 0, stop_cnt = 0;
  logic [7:0] exp_q[$];
  logic [7:0] slv_q[$];
  logic       slv_send = 1'b0, slv_ack = 1'b1, slv_last_ack = 1'b1;
  logic [7:0] slv_sh = '0, slv_cur = '0;
  int         slv_cnt = 0;

  always #(CLK_P/2) clk = !clk;

  i2c_host_ctrl u_i2c_host_ctrl (
    .clk_i(clk), .rst_ni, .addr_i(addr), .wr_i(wr), .rd_i(rd), .wdata_i(wdata),
    .rdata_o(rdata), .scl_i(scl_w), .sda_i(sda_w), .scl_oe_o(scl_oe), .sda_oe_o(sda_oe));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bus model: START/STOP counters and slave
  always @(negedge sda_w) if (rst_ni && scl_w) begin start_cnt++; slv_cnt = 0; end
  always @(posedge sda_w) if (rst_ni && scl_w) stop_cnt++;

  always @(negedge scl_w) if (rst_ni) begin
    if (slv_send && slv_cnt == 0 && slv_q.size() > 0) slv_cur = slv_q.pop_front();
    if (slv_send && slv_cnt < 8)                  slv_low = !slv_cur[7-slv_cnt];
    else if (!slv_send && slv_cnt == 8 && slv_ack) slv_low = 1'b1;
    else                                          slv_low = 1'b0;
  end

  always @(posedge scl_w) if (rst_ni) begin
    if (slv_cnt < 8) slv_sh = {slv_sh[6:0], sda_w};
    if (slv_cnt == 7 && !slv_send) begin  // scoreboard monitor, R5
      if (exp_q.size() == 0) chk("R5 unexpected byte", slv_sh, 32'hxx);
      else chk("R5 byte sent MSB first", slv_sh, exp_q.pop_front());
    end
    if (slv_cnt == 8) begin
      slv_last_ack = sda_w;
      if (slv_send && sda_w) slv_send = 1'b0;
    end
    slv_cnt = (slv_cnt == 8) ? 0 : slv_cnt + 1;
  end

  task automatic reg_wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic reg_rd(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; rd = 1'b1; #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);  // driver
    exp_q.push_back(b);
    reg_wr(5'h10, {8'h00, b});
  endtask

  task automatic wait_flag(input string req);
    logic [15:0] v;
    for (int n = 0; n < 20000; n++) begin
      reg_rd(5'h0C, v);
      if (v[1]) return;
    end
    chk(req, 0, 1);
  endtask

  task automatic wait_busy(input logic lvl, input string req);
    logic [15:0] v;
    for (int n = 0; n < 5000; n++) begin
      reg_rd(5'h0C, v);
      if (v[5] == lvl) return;
    end
    chk(req, !lvl, lvl);
  endtask

  initial begin
    #(150000 * CLK_P);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int s0, p0;
    time t1, t2, t3;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    for (int i = 0; i < 5; i++) begin
      reg_rd(5'(i * 4), v);
      chk("R1 register reset", v, 0);
    end
    chk("R1 lines released", {scl_oe, sda_oe}, 0);

    // R2 register map
    reg_wr(5'h00, 16'h005A);
    reg_wr(5'h04, 16'h0016);
    reg_wr(5'h08, 16'h80C7);
    reg_rd(5'h00, v); chk("R2 address reg", v, 16'h005A);
    reg_rd(5'h04, v); chk("R2 divider reg", v, 16'h0016);
    reg_rd(5'h08, v); chk("R2 control keeps 7,5,4,3", v, 16'h0080);

    // R3 START
    s0 = start_cnt; p0 = stop_cnt;
    reg_wr(5'h08, 16'h00B0);
    wait_busy(1'b1, "R3 busy after START");
    chk("R3 one START", start_cnt - s0, 1);
    repeat (400) @(negedge clk);

    // R5 + R9 first byte at divider 0x16
    s0 = start_cnt;
    send_byte(8'hA5);
    @(posedge scl_w); t1 = $time;
    @(posedge scl_w); t2 = $time;
    @(negedge scl_w); t3 = $time;
    chk("R9 SCL period", 32'((t2 - t1) / CLK_P), 768);
    chk("R9 SCL high half", 32'((t3 - t2) / CLK_P), 384);
    wait_flag("R5 flag after byte");
    reg_rd(5'h0C, v); chk("R5 status acked", v, 16'h0022);

    // R8 flag clearing
    reg_wr(5'h0C, 16'h0002);
    reg_rd(5'h0C, v); chk("R8 write 1 keeps flag", v[1], 1);
    reg_wr(5'h0C, 16'h0000);
    reg_rd(5'h0C, v); chk("R8 write 0 clears flag", v[1], 0);

    // faster bytes, R5 no-ack, R10
    reg_wr(5'h04, 16'h0000);
    slv_ack = 1'b0;
    send_byte(8'h3C);
    wait_flag("R5 flag nack byte");
    reg_rd(5'h0C, v); chk("R5 status no ack", v, 16'h0023);
    reg_wr(5'h0C, 16'h0000);
    slv_ack = 1'b1;
    send_byte(8'h81);
    wait_flag("R5 flag third byte");
    reg_rd(5'h0C, v); chk("R5 status acked again", v, 16'h0022);
    reg_wr(5'h0C, 16'h0000);
    chk("R10 no START during bytes", start_cnt - s0, 0);
    chk("R10 no STOP during bytes", stop_cnt - p0, 0);

    // R7 repeated START, switch to receive
    slv_q.push_back(8'hC3); slv_q.push_back(8'h5E);
    slv_send = 1'b1;
    s0 = start_cnt;
    reg_wr(5'h08, 16'h00A4);
    repeat (200) @(negedge clk);
    chk("R7 one new START", start_cnt - s0, 1);
    chk("R7 no STOP", stop_cnt - p0, 0);
    reg_rd(5'h0C, v); chk("R7 busy held", v[5], 1);
    reg_rd(5'h08, v); chk("R7 repeat bit reads 0", v, 16'h00A0);

    // R6 receive
    reg_rd(5'h10, v);
    wait_flag("R6 flag first rx");
    chk("R6 master acked", slv_last_ack, 0);
    reg_wr(5'h0C, 16'h0000);
    reg_wr(5'h08, 16'h00A8);
    reg_rd(5'h10, v); chk("R6 first rx byte", v, 16'h00C3);
    wait_flag("R6 flag second rx");
    chk("R6 master no-ack", slv_last_ack, 1);
    reg_wr(5'h0C, 16'h0000);

    // R4 STOP
    reg_wr(5'h08, 16'h0080);
    wait_busy(1'b0, "R4 busy clears after STOP");
    chk("R4 one STOP", stop_cnt - p0, 1);
    reg_rd(5'h10, v); chk("R6 second rx byte", v, 16'h005E);

    // R11 foreign master
    s0 = start_cnt;
    tb_sda_low = 1'b1;
    repeat (10) @(negedge clk);
    reg_rd(5'h0C, v); chk("R11 busy on foreign START", v[5], 1);
    reg_wr(5'h08, 16'h00B0);
    repeat (200) @(negedge clk);
    chk("R11 no own START while busy", {scl_oe, sda_oe}, 0);
    chk("R11 only foreign START seen", start_cnt - s0, 1);
    reg_wr(5'h08, 16'h0080);
    tb_sda_low = 1'b0;
    repeat (10) @(negedge clk);
    reg_rd(5'h0C, v); chk("R11 idle on foreign STOP", v[5], 0);

    // R12 enable drop mid-byte
    reg_wr(5'h08, 16'h00B0);
    repeat (100) @(negedge clk);
    reg_wr(5'h10, 16'h00FF);
    repeat (3) @(posedge scl_w);
    reg_wr(5'h08, 16'h0000);
    @(negedge clk);
    chk("R12 lines released", {scl_oe, sda_oe}, 0);
    reg_rd(5'h0C, v); chk("R12 status cleared", v, 0);

    chk("R5 all sent bytes seen", exp_q.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule